// File: doc/BRIEF.md
# Multi-Slot Frame Commit Buffer

This block sits between a frame checker and a downstream consumer. It holds a parameterised number of slots, each of which stores exactly one Ethernet frame. The upstream writer streams bytes into a slot it claims at the first byte of a frame. When the frame has been checked, the writer pulses `good_i` to keep it or `bad_i` to throw it away. When every slot is occupied as a new frame begins, that whole frame is discarded. More slots let more frames wait before any are lost.

A round-robin drainer scans the committed slots. It streams one slot at a time to the output as 9-bit words, with a start bit on the first word of each frame and a last flag on the final word. Output words move only when the consumer asserts `out_ready_i`. A drained slot becomes free again right after its final word is taken.

Top module: `fcb_commit_buf`

## Requirements
- R1: After reset every bit of `slot_ready_o` is 1 and `out_valid_o` is 0.
- R2: A frame's first byte (`in_valid_i` with `in_sof_i`) claims the lowest-numbered slot whose ready bit is 1. That ready bit reads 0 from the next cycle, and at most one slot is claimed per cycle.
- R3: After `good_i` closes a frame, the frame appears on the output exactly once, with the bytes in write order in `out_data_o[7:0]`.
- R4: `bad_i` discards the open frame, and its slot reads ready again in the next cycle. No word of that frame is output.
- R5: If no slot is ready when a frame's first byte arrives, the whole frame is dropped: nothing is output and `slot_ready_o` is unchanged. No slot is claimed in a cycle without `in_valid_i`.
- R6: A frame of exactly `SLOT_BYTES` bytes is kept. A byte beyond `SLOT_BYTES` flushes the frame, and the later `good_i` has no effect.
- R7: The drainer grants committed slots in round-robin order, starting from the slot after the last one granted, not by lowest index.
- R8: `out_data_o[8]` is 1 on the first word of each frame and 0 on all other words.
- R9: `out_last_o` is 1 only together with `out_valid_o`, and only on the final word of a frame.
- R10: A drained slot reads ready in the cycle after its final word is accepted.
- R11: While `out_valid_o` is 1 and `out_ready_i` is 0, the output word and the last flag hold steady.
- R12: A first byte that arrives while a frame is still open flushes the open frame. The new frame takes the lowest slot that was ready before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| in_data_i | input | 8 | frame byte from the writer |
| in_valid_i | input | 1 | byte strobe |
| in_sof_i | input | 1 | marks the first byte of a frame |
| good_i | input | 1 | pulse: keep the open frame |
| bad_i | input | 1 | pulse: discard the open frame |
| slot_ready_o | output | NUM_SLOTS | per-slot free flag |
| out_data_o | output | 9 | drained word, bit 8 is the start bit |
| out_valid_o | output | 1 | drained word is valid |
| out_last_o | output | 1 | final word of the current frame |
| out_ready_i | input | 1 | consumer accepts the word |

## Verification
The assertions check the cycle-level rules on every cycle:
- the output holds still during a stall;
- the start bit matches the position within the frame;
- the last flag appears only with valid;
- no more than one slot is claimed per cycle, and none without a byte;
- a slot frees up right after its final word.

Only the bench scenarios can show the rest:
- which slot is picked;
- that the drain order is round-robin rather than fixed-priority;
- whole-frame loss when every slot is busy;
- the overflow boundary at exactly `SLOT_BYTES`;
- the flush on a restarted frame;
- that frame contents arrive intact.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_FILL = 2'd1,
    SL_HELD = 2'd2
  } slot_state_e;
endpackage

// File: rtl/fcb_slot.sv
module fcb_slot
  import fcb_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 2048,
  localparam int unsigned CNT_W = $clog2(SLOT_BYTES + 1),
  localparam int unsigned ADR_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       commit_i,
  input  logic       flush_i,
  input  logic       pop_i,
  output logic       ready_o,
  output logic       held_o,
  output logic       at_cap_o,
  output logic [7:0] rd_data_o,
  output logic       rd_first_o,
  output logic       rd_last_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOT_BYTES);

  slot_state_e      state_q;
  logic [CNT_W-1:0] cnt_q, rd_q, cnt_nxt;
  logic [7:0]       mem_q [SLOT_BYTES];

  assign cnt_nxt = cnt_q + (wr_i ? CNT_W'(1) : CNT_W'(0));

  always_ff @(posedge clk_i) begin
    if (wr_i && cnt_q < CAP) mem_q[cnt_q[ADR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SL_FREE;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else if (flush_i) begin
      state_q <= SL_FREE;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else begin
      unique case (state_q)
        SL_FREE, SL_FILL: begin
          cnt_q <= cnt_nxt;
          if (commit_i) state_q <= (cnt_nxt == '0) ? SL_FREE : SL_HELD;
          else if (wr_i) state_q <= SL_FILL;
        end
        SL_HELD: begin
          if (pop_i) begin
            if (rd_last_o) begin
              state_q <= SL_FREE;
              cnt_q   <= '0;
              rd_q    <= '0;
            end else begin
              rd_q <= rd_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= SL_FREE;
      endcase
    end
  end

  assign ready_o    = (state_q == SL_FREE);
  assign held_o     = (state_q == SL_HELD);
  assign at_cap_o   = (cnt_q == CAP);
  assign rd_data_o  = mem_q[rd_q[ADR_W-1:0]];
  assign rd_first_o = (rd_q == '0);
  assign rd_last_o  = ((rd_q + CNT_W'(1)) == cnt_q);
endmodule

// File: rtl/fcb_rr_arb.sv
module fcb_rr_arb #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] held_i,
  input  logic                 done_i,
  output logic                 busy_o,
  output logic [IDX_W-1:0]     grant_o
);
  logic [IDX_W-1:0] ptr_q, pick;
  logic             found;

  // first held slot at or after the pointer, wrapping
  always_comb begin
    int unsigned j;
    found = 1'b0;
    pick  = '0;
    for (int unsigned k = 0; k < NUM_SLOTS; k++) begin
      j = (int'(ptr_q) + k) % NUM_SLOTS;
      if (!found && held_i[j]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      grant_o <= '0;
      ptr_q   <= '0;
    end else if (!busy_o) begin
      if (found) begin
        busy_o  <= 1'b1;
        grant_o <= pick;
        ptr_q   <= IDX_W'((int'(pick) + 1) % NUM_SLOTS);
      end
    end else if (done_i) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fcb_commit_buf.sv
module fcb_commit_buf #(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned SLOT_BYTES = 2048
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           in_data_i,
  input  logic                 in_valid_i,
  input  logic                 in_sof_i,
  input  logic                 good_i,
  input  logic                 bad_i,
  output logic [NUM_SLOTS-1:0] slot_ready_o,
  output logic [8:0]           out_data_o,
  output logic                 out_valid_o,
  output logic                 out_last_o,
  input  logic                 out_ready_i
);
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] wr, commit, flush, pop, ready, held, at_cap, first, last;
  logic [7:0]           rd_data [NUM_SLOTS];
  logic                 active_q, active_d, any_ready, busy, done;
  logic [IDX_W-1:0]     sel_q, sel_d, low, grant;

  always_comb begin
    any_ready = |ready;
    low = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) if (ready[i]) low = IDX_W'(i);
  end

  // write side: byte first, then close by bad (priority) or good
  always_comb begin
    logic             open_v;
    logic [IDX_W-1:0] cur_v;
    open_v = active_q;
    cur_v  = sel_q;
    wr     = '0;
    commit = '0;
    flush  = '0;
    if (in_valid_i) begin
      if (in_sof_i) begin
        if (open_v) flush[cur_v] = 1'b1;
        if (any_ready) begin
          wr[low] = 1'b1;
          open_v  = 1'b1;
          cur_v   = low;
        end else begin
          open_v = 1'b0;
        end
      end else if (open_v) begin
        if (at_cap[cur_v]) begin
          flush[cur_v] = 1'b1;
          open_v       = 1'b0;
        end else begin
          wr[cur_v] = 1'b1;
        end
      end
    end
    if (open_v && bad_i) begin
      flush[cur_v] = 1'b1;
      open_v       = 1'b0;
    end else if (open_v && good_i) begin
      commit[cur_v] = 1'b1;
      open_v        = 1'b0;
    end
    active_d = open_v;
    sel_d    = cur_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      active_q <= active_d;
      sel_q    <= sel_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign pop[g] = busy && (grant == IDX_W'(g)) && out_ready_i;
    fcb_slot #(.SLOT_BYTES(SLOT_BYTES)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr[g]),
      .wr_data_i (in_data_i),
      .commit_i  (commit[g]),
      .flush_i   (flush[g]),
      .pop_i     (pop[g]),
      .ready_o   (ready[g]),
      .held_o    (held[g]),
      .at_cap_o  (at_cap[g]),
      .rd_data_o (rd_data[g]),
      .rd_first_o(first[g]),
      .rd_last_o (last[g])
    );
  end

  assign done = busy && out_ready_i && last[grant];

  fcb_rr_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .held_i (held),
    .done_i (done),
    .busy_o (busy),
    .grant_o(grant)
  );

  assign slot_ready_o = ready;
  assign out_valid_o  = busy;
  assign out_data_o   = {first[grant], rd_data[grant]};
  assign out_last_o   = busy && last[grant];
endmodule

// File: rtl/fcb_chk.sv
module fcb_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 bad_i,
  input logic [NUM_SLOTS-1:0] slot_ready_o,
  input logic [8:0]           out_data_o,
  input logic                 out_valid_o,
  input logic                 out_last_o,
  input logic                 out_ready_i
);
  logic mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mid_q <= 1'b0;
    else if (out_valid_o && out_ready_i) mid_q <= !out_last_o;
  end

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  a_r8_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o[8] == !mid_q));

  a_r9_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r10_free_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o && !in_valid_i && !bad_i
    |=> $countones(slot_ready_o) == $countones($past(slot_ready_o)) + 1);

  a_r2_one_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> $countones($past(slot_ready_o) & ~slot_ready_o) <= 1);

  a_r5_no_claim_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($past(slot_ready_o) & ~slot_ready_o) == '0);
endmodule

bind fcb_commit_buf fcb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .bad_i       (bad_i),
  .slot_ready_o(slot_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/sim_fcb_commit_buf.sv
module sim_fcb_commit_buf;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    in_data;
  logic          in_valid, in_sof, good, bad, out_ready;
  logic [NS-1:0] slot_ready;
  logic [8:0]    out_data;
  logic          out_valid, out_last;

  int n_chk = 0;
  int n_err = 0;
  logic [9:0] exp_q[$];
  logic [9:0] e;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fcb_commit_buf #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_sof_i(in_sof), .good_i(good), .bad_i(bad), .slot_ready_o(slot_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last),
    .out_ready_i(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    return 8'((seed * 37 + i * 5 + 1) & 255);
  endfunction

  // fin: 0 good, 1 bad, 2 leave open
  task automatic send_frame(input int seed, input int len, input int fin);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_data = gen(seed, i);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0;
    if (fin < 2) begin
      good = (fin == 0); bad = (fin == 1);
      @(posedge clk); #1;
      good = 1'b0; bad = 1'b0;
    end
  endtask

  task automatic expect_frame(input int seed, input int len);
    for (int i = 0; i < len; i++) exp_q.push_back({i == len - 1, i == 0, gen(seed, i)});
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 R4 R5 R6 unexpected word", {22'd0, out_last, out_data}, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check({out_last, out_data} == e, "R3 R8 R9 word", {22'd0, out_last, out_data}, {22'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [8:0] held_word;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
    good = 1'b0; bad = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1
    check(slot_ready == 4'hF, "R1 ready after reset", slot_ready, 4'hF);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R3 basic frame
    out_ready = 1'b1;
    expect_frame(1, 6);
    send_frame(1, 6, 0);
    wait_drain();

    // R4 bad flush
    send_frame(2, 5, 1);
    check(slot_ready == 4'hF, "R4 slot freed after bad", slot_ready, 4'hF);
    repeat (4) @(posedge clk); #1;

    // R2 R7 R10 R11: expected order A B D C
    out_ready = 1'b0;
    expect_frame(3, 4); expect_frame(4, 3); expect_frame(6, 5); expect_frame(5, 4);
    send_frame(3, 4, 0);
    check(slot_ready == 4'b1110, "R2 lowest slot claimed", slot_ready, 4'b1110);
    send_frame(4, 3, 0);
    check(slot_ready == 4'b1100, "R2 next lowest slot", slot_ready, 4'b1100);
    held_word = out_data;
    check(out_valid && held_word == {1'b1, gen(3, 0)}, "R8 R11 first word presented", {23'd0, held_word}, {23'd0, 1'b1, gen(3, 0)});
    repeat (3) @(posedge clk); #1;
    check(out_valid && out_data == held_word, "R11 stall hold", out_data, held_word);
    out_ready = 1'b1;
    do @(negedge clk); while (!(out_valid && out_last));
    check(slot_ready[0] == 1'b0, "R10 busy before last taken", slot_ready, 0);
    @(posedge clk); #1;
    out_ready = 1'b0;
    check(slot_ready[0] == 1'b1, "R10 free after last", slot_ready, 1);
    send_frame(5, 4, 0);
    check(slot_ready == 4'b1100, "R2 freed slot reused", slot_ready, 4'b1100);
    send_frame(6, 5, 0);
    check(slot_ready == 4'b1000, "R2 slot two claimed", slot_ready, 4'b1000);
    out_ready = 1'b1;
    wait_drain();
    check(slot_ready == 4'hF, "R7 all drained", slot_ready, 4'hF);

    // R5 drop when full
    out_ready = 1'b0;
    for (int s = 7; s < 11; s++) expect_frame(s, 3);
    for (int s = 7; s < 11; s++) send_frame(s, 3, 0);
    check(slot_ready == 4'h0, "R5 all slots busy", slot_ready, 4'h0);
    send_frame(11, 4, 0);
    check(slot_ready == 4'h0, "R5 ready unchanged by drop", slot_ready, 4'h0);
    out_ready = 1'b1;
    wait_drain();
    check(slot_ready == 4'hF, "R5 slots free after drain", slot_ready, 4'hF);

    // R6 capacity boundary and overflow
    expect_frame(12, SB);
    send_frame(12, SB, 0);
    wait_drain();
    send_frame(13, SB + 1, 0);
    repeat (5) @(posedge clk); #1;
    check(slot_ready == 4'hF && !out_valid, "R6 overflow flushed", {27'd0, out_valid, slot_ready}, 32'hF);

    // R12 restart flushes open frame
    out_ready = 1'b0;
    expect_frame(15, 4);
    send_frame(14, 3, 2);
    send_frame(15, 4, 0);
    check(slot_ready == 4'b1101, "R12 old slot flushed, new in slot one", slot_ready, 4'b1101);
    out_ready = 1'b1;
    wait_drain();

    check(exp_q.size() == 0, "R3 all frames delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule